// File: doc/BRIEF.md
# Banked Dual-Port Operand Memory

This block stores operands for a modular arithmetic core with two multipliers. Storage is split into banks of 32-bit words, one bank per multiplier. Each bank is a synchronous dual-port RAM. Each multiplier drives port A of its own bank directly, at any time. No operand is staged in registers on the way.

Port B of every bank is shared between two users: an internal copy engine and an external host. The engine's busy flag decides which user owns port B. While busy is high, the engine owns port B of every bank, and host requests are held back by a low ready signal. While busy is low, the host can read or write any bank through port B.

The copy engine moves a run of words from one bank to another, or within one bank. This keeps the banks consistent when one multiplier needs a result that the other multiplier produced.

Top module: `opmem_subsys`

## Requirements
- R1: After reset, `busy_o` is 0, `host_ready_o` is 1, `host_rvalid_o` is 0, and every port A read data word is 0.
- R2: A port A access with `pa_en_i` set updates that bank's `pa_rdata_o` slice one cycle later. This holds for both reads and writes, and it holds while a copy is running. Each bank is independent of the others.
- R3: When port A and port B write the same address of a bank in the same cycle, the port A data is stored.
- R4: Reads are read-first. A read on either port returns the word stored before the clock edge, even if either port writes that address on the same edge.
- R5: While `busy_o` is 0, a host request is serviced at the next edge. A host write stores `host_wdata_i` into bank `host_bank_i` at `host_addr_i`. A host read raises `host_rvalid_o` for one cycle after that edge, with the addressed word on `host_rdata_o`.
- R6: While `busy_o` is 1, `host_ready_o` is 0 and a host request has no effect on the memory. A request that is kept asserted is serviced after busy falls, so no request is lost.
- R7: A copy command is accepted on an edge where busy is 0, `copy_valid_i` is 1 and `copy_len_i` is nonzero. For a command with different source and destination banks, busy stays high for exactly len+1 cycles, and the engine moves one word per cycle. Word i is read from source base+i and written to destination base+i.
- R8: A copy within a single bank alternates one read cycle and one write cycle, so busy stays high for exactly 2*len cycles. The result is the same as in R7.
- R9: A copy command with `copy_len_i` equal to 0 is ignored. A copy command that arrives while busy is 1 is also ignored.
- R10: Copy addresses wrap modulo the bank depth, which is 2^ADDR_W words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pa_en_i | input | NUM_BANKS | Port A enable, one bit per bank |
| pa_we_i | input | NUM_BANKS | Port A write enable, one bit per bank |
| pa_addr_i | input | NUM_BANKS*ADDR_W | Port A addresses, bank b in slice b |
| pa_wdata_i | input | NUM_BANKS*DATA_W | Port A write data |
| pa_rdata_o | output | NUM_BANKS*DATA_W | Port A read data |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_bank_i | input | BANK_W | Host target bank |
| host_addr_i | input | ADDR_W | Host word address |
| host_wdata_i | input | DATA_W | Host write data |
| host_ready_o | output | 1 | Host request is taken on this edge |
| host_rvalid_o | output | 1 | Host read data valid |
| host_rdata_o | output | DATA_W | Host read data |
| copy_valid_i | input | 1 | Copy command strobe |
| copy_src_bank_i | input | BANK_W | Copy source bank |
| copy_dst_bank_i | input | BANK_W | Copy destination bank |
| copy_src_addr_i | input | ADDR_W | Copy source base address |
| copy_dst_addr_i | input | ADDR_W | Copy destination base address |
| copy_len_i | input | ADDR_W+1 | Copy word count |
| busy_o | output | 1 | Copy engine owns port B of all banks |

## Verification
The bench targets several corner cases:
- A port A write that hits the same address as a copy write, or as a host write, in the same cycle. A design with the wrong port priority keeps the port B data.
- A host write that is held through a whole copy. A design that drops it or services it early leaves the wrong word behind. A design that services it early also changes what port A reads during the copy.
- Busy-cycle counts for cross-bank and same-bank copies, including a copy whose addresses wrap. A wrong count or wrong pacing shows up as an off-by-one in the busy window or as wrong destination words.
- A zero-length command and a command issued while busy. Either one starting a copy would raise busy or corrupt an untouched region.

// File: rtl/opmem_pkg.sv
package opmem_pkg;

  // Owner of a bank's port B in a given cycle
  typedef enum logic [1:0] {
    PB_IDLE   = 2'd0,
    PB_HOST   = 2'd1,
    PB_ENG_RD = 2'd2,
    PB_ENG_WR = 2'd3
  } pb_owner_e;

endpackage

// File: rtl/opmem_bank.sv
module opmem_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // port A written last so it wins a same-address collision
  always_ff @(posedge clk_i) begin
    if (b_en_i && b_we_i) mem_q[b_addr_i] <= b_wdata_i;
    if (a_en_i && a_we_i) mem_q[a_addr_i] <= a_wdata_i;
  end

  // read-first on both ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_en_i) a_rdata_o <= mem_q[a_addr_i];
      if (b_en_i) b_rdata_o <= mem_q[b_addr_i];
    end
  end

  assert_a_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && a_we_i && b_en_i && b_we_i && (a_addr_i == b_addr_i))
    |=> (mem_q[$past(a_addr_i)] == $past(a_wdata_i)));

endmodule

// File: rtl/opmem_copy_engine.sv
module opmem_copy_engine #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1,
  parameter int LEN_W     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [BANK_W-1:0] cmd_src_bank_i,
  input  logic [BANK_W-1:0] cmd_dst_bank_i,
  input  logic [ADDR_W-1:0] cmd_src_addr_i,
  input  logic [ADDR_W-1:0] cmd_dst_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [DATA_W-1:0] rdata_i [NUM_BANKS],
  output logic              busy_o,
  output logic              rd_en_o,
  output logic [BANK_W-1:0] rd_bank_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  logic              busy_q;
  logic              same_q;
  logic              wr_pend_q;
  logic [BANK_W-1:0] src_bank_q, dst_bank_q;
  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic [LEN_W-1:0]  rd_left_q;
  logic [LEN_W-1:0]  rd_left_d;
  logic              accept;

  assign accept    = !busy_q && cmd_valid_i && (cmd_len_i != '0);
  // a single-bank copy cannot read and write port B together
  assign rd_en_o   = busy_q && (rd_left_q != '0) && !(same_q && wr_pend_q);
  assign wr_en_o   = busy_q && wr_pend_q;
  assign rd_left_d = rd_left_q - LEN_W'(rd_en_o);

  assign busy_o    = busy_q;
  assign rd_bank_o = src_bank_q;
  assign rd_addr_o = rd_addr_q;
  assign wr_bank_o = dst_bank_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = rdata_i[src_bank_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      same_q     <= 1'b0;
      wr_pend_q  <= 1'b0;
      src_bank_q <= '0;
      dst_bank_q <= '0;
      rd_addr_q  <= '0;
      wr_addr_q  <= '0;
      rd_left_q  <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      same_q     <= (cmd_src_bank_i == cmd_dst_bank_i);
      wr_pend_q  <= 1'b0;
      src_bank_q <= cmd_src_bank_i;
      dst_bank_q <= cmd_dst_bank_i;
      rd_addr_q  <= cmd_src_addr_i;
      wr_addr_q  <= cmd_dst_addr_i;
      rd_left_q  <= cmd_len_i;
    end else if (busy_q) begin
      wr_pend_q <= rd_en_o;
      rd_left_q <= rd_left_d;
      if (rd_en_o) rd_addr_q <= rd_addr_q + 1'b1;
      if (wr_en_o) wr_addr_q <= wr_addr_q + 1'b1;
      busy_q <= rd_en_o || (rd_left_d != '0);
    end
  end

  assert_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && cmd_valid_i && (cmd_len_i != '0)) |=> (busy_q && rd_en_o));

  assert_end_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(wr_en_o));

  assert_same_bank_pace_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && same_q && wr_en_o) |=> !wr_en_o);

  assert_busy_cmd_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmd_valid_i) |=> ($stable(src_bank_q) && $stable(dst_bank_q) && $stable(same_q)));

endmodule

// File: rtl/opmem_portb_mux.sv
module opmem_portb_mux
  import opmem_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int BANK_W   = 1,
  parameter int BANK_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              eng_rd_en_i,
  input  logic [BANK_W-1:0] eng_rd_bank_i,
  input  logic [ADDR_W-1:0] eng_rd_addr_i,
  input  logic              eng_wr_en_i,
  input  logic [BANK_W-1:0] eng_wr_bank_i,
  input  logic [ADDR_W-1:0] eng_wr_addr_i,
  input  logic [DATA_W-1:0] eng_wr_data_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [BANK_W-1:0] host_bank_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              en_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);

  localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_IDX);

  pb_owner_e owner;
  logic      eng_rd_hit, eng_wr_hit;

  assign eng_rd_hit = eng_rd_en_i && (eng_rd_bank_i == MY_BANK);
  assign eng_wr_hit = eng_wr_en_i && (eng_wr_bank_i == MY_BANK);

  always_comb begin
    owner = PB_IDLE;
    if (busy_i) begin
      if (eng_wr_hit)      owner = PB_ENG_WR;
      else if (eng_rd_hit) owner = PB_ENG_RD;
    end else if (host_req_i && (host_bank_i == MY_BANK)) begin
      owner = PB_HOST;
    end
  end

  always_comb begin
    en_o    = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    unique case (owner)
      PB_HOST: begin
        en_o = 1'b1; we_o = host_we_i; addr_o = host_addr_i; wdata_o = host_wdata_i;
      end
      PB_ENG_RD: begin
        en_o = 1'b1; addr_o = eng_rd_addr_i;
      end
      PB_ENG_WR: begin
        en_o = 1'b1; we_o = 1'b1; addr_o = eng_wr_addr_i; wdata_o = eng_wr_data_i;
      end
      default: ;
    endcase
  end

  assert_host_fenced_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && host_req_i && (host_bank_i == MY_BANK) && !eng_rd_hit && !eng_wr_hit) |-> !en_o);

endmodule

// File: rtl/opmem_subsys.sv
module opmem_subsys #(
  parameter  int DATA_W    = 32,
  parameter  int ADDR_W    = 8,
  parameter  int NUM_BANKS = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int LEN_W     = ADDR_W + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_BANKS-1:0]          pa_en_i,
  input  logic [NUM_BANKS-1:0]          pa_we_i,
  input  logic [NUM_BANKS*ADDR_W-1:0]   pa_addr_i,
  input  logic [NUM_BANKS*DATA_W-1:0]   pa_wdata_i,
  output logic [NUM_BANKS*DATA_W-1:0]   pa_rdata_o,
  input  logic                          host_req_i,
  input  logic                          host_we_i,
  input  logic [BANK_W-1:0]             host_bank_i,
  input  logic [ADDR_W-1:0]             host_addr_i,
  input  logic [DATA_W-1:0]             host_wdata_i,
  output logic                          host_ready_o,
  output logic                          host_rvalid_o,
  output logic [DATA_W-1:0]             host_rdata_o,
  input  logic                          copy_valid_i,
  input  logic [BANK_W-1:0]             copy_src_bank_i,
  input  logic [BANK_W-1:0]             copy_dst_bank_i,
  input  logic [ADDR_W-1:0]             copy_src_addr_i,
  input  logic [ADDR_W-1:0]             copy_dst_addr_i,
  input  logic [LEN_W-1:0]              copy_len_i,
  output logic                          busy_o
);

  logic              busy;
  logic              eng_rd_en, eng_wr_en;
  logic [BANK_W-1:0] eng_rd_bank, eng_wr_bank;
  logic [ADDR_W-1:0] eng_rd_addr, eng_wr_addr;
  logic [DATA_W-1:0] eng_wr_data;
  logic [DATA_W-1:0] pb_rdata [NUM_BANKS];
  logic              host_rvalid_q;
  logic [BANK_W-1:0] host_rbank_q;
  logic              host_take_rd;

  opmem_copy_engine #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .LEN_W(LEN_W)
  ) u_copy (
    .clk_i, .rst_ni,
    .cmd_valid_i   (copy_valid_i),
    .cmd_src_bank_i(copy_src_bank_i),
    .cmd_dst_bank_i(copy_dst_bank_i),
    .cmd_src_addr_i(copy_src_addr_i),
    .cmd_dst_addr_i(copy_dst_addr_i),
    .cmd_len_i     (copy_len_i),
    .rdata_i       (pb_rdata),
    .busy_o        (busy),
    .rd_en_o       (eng_rd_en),
    .rd_bank_o     (eng_rd_bank),
    .rd_addr_o     (eng_rd_addr),
    .wr_en_o       (eng_wr_en),
    .wr_bank_o     (eng_wr_bank),
    .wr_addr_o     (eng_wr_addr),
    .wr_data_o     (eng_wr_data)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic              pb_en, pb_we;
    logic [ADDR_W-1:0] pb_addr;
    logic [DATA_W-1:0] pb_wdata;

    opmem_portb_mux #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_IDX(b)
    ) u_mux (
      .clk_i, .rst_ni,
      .busy_i       (busy),
      .eng_rd_en_i  (eng_rd_en),
      .eng_rd_bank_i(eng_rd_bank),
      .eng_rd_addr_i(eng_rd_addr),
      .eng_wr_en_i  (eng_wr_en),
      .eng_wr_bank_i(eng_wr_bank),
      .eng_wr_addr_i(eng_wr_addr),
      .eng_wr_data_i(eng_wr_data),
      .host_req_i,
      .host_we_i,
      .host_bank_i,
      .host_addr_i,
      .host_wdata_i,
      .en_o         (pb_en),
      .we_o         (pb_we),
      .addr_o       (pb_addr),
      .wdata_o      (pb_wdata)
    );

    opmem_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
      .clk_i, .rst_ni,
      .a_en_i   (pa_en_i[b]),
      .a_we_i   (pa_we_i[b]),
      .a_addr_i (pa_addr_i[b*ADDR_W +: ADDR_W]),
      .a_wdata_i(pa_wdata_i[b*DATA_W +: DATA_W]),
      .a_rdata_o(pa_rdata_o[b*DATA_W +: DATA_W]),
      .b_en_i   (pb_en),
      .b_we_i   (pb_we),
      .b_addr_i (pb_addr),
      .b_wdata_i(pb_wdata),
      .b_rdata_o(pb_rdata[b])
    );
  end

  assign host_take_rd = host_req_i && !host_we_i && !busy
                        && (int'(host_bank_i) < NUM_BANKS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rvalid_q <= 1'b0;
      host_rbank_q  <= '0;
    end else begin
      host_rvalid_q <= host_take_rd;
      if (host_take_rd) host_rbank_q <= host_bank_i;
    end
  end

  assign busy_o        = busy;
  assign host_ready_o  = !busy;
  assign host_rvalid_o = host_rvalid_q;
  assign host_rdata_o  = pb_rdata[host_rbank_q];

  assert_rvalid_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rvalid_o |-> $past(host_req_i && !host_we_i && host_ready_o));

  assert_ready_tracks_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !host_ready_o) |-> busy_o);

endmodule

// File: tb/opmem_subsys_bench.sv
`timescale 1ns/1ps
module opmem_subsys_bench;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NB-1:0]    pa_en = '0, pa_we = '0;
  logic [NB*AW-1:0] pa_addr = '0;
  logic [NB*DW-1:0] pa_wdata = '0;
  logic [NB*DW-1:0] pa_rdata;
  logic             host_req = 1'b0, host_we = 1'b0;
  logic             host_bank = 1'b0;
  logic [AW-1:0]    host_addr = '0;
  logic [DW-1:0]    host_wdata = '0;
  logic             host_ready, host_rvalid;
  logic [DW-1:0]    host_rdata;
  logic             cp_valid = 1'b0;
  logic             cp_src_bank = 1'b0, cp_dst_bank = 1'b0;
  logic [AW-1:0]    cp_src_addr = '0, cp_dst_addr = '0;
  logic [AW:0]      cp_len = '0;
  logic             busy;

  opmem_subsys u_opmem_subsys (
    .clk_i(clk), .rst_ni(rst_n),
    .pa_en_i(pa_en), .pa_we_i(pa_we), .pa_addr_i(pa_addr), .pa_wdata_i(pa_wdata),
    .pa_rdata_o(pa_rdata),
    .host_req_i(host_req), .host_we_i(host_we), .host_bank_i(host_bank),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_ready_o(host_ready), .host_rvalid_o(host_rvalid), .host_rdata_o(host_rdata),
    .copy_valid_i(cp_valid), .copy_src_bank_i(cp_src_bank), .copy_dst_bank_i(cp_dst_bank),
    .copy_src_addr_i(cp_src_addr), .copy_dst_addr_i(cp_dst_addr), .copy_len_i(cp_len),
    .busy_o(busy)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int b, input int a);
    return {8'hA5, 8'(b), 8'h3C, 8'(a)};
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [DW-1:0] mdl [NB][DEPTH];
  logic [DW-1:0] exp_pa [NB];
  logic          exp_hrv;
  logic [DW-1:0] exp_hrd;
  bit            m_busy;
  int            m_k, m_t, m_len;
  bit            m_same;
  int            m_src, m_dst, m_sa, m_da;
  logic [DW-1:0] m_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) exp_pa[b] = '0;
      exp_hrv = 1'b0;
      exp_hrd = '0;
      m_busy = 1'b0;
      m_q.delete();
    end else begin
      bit            cw;
      int            cw_a;
      logic [DW-1:0] cw_d;
      bit            h_take;
      cw = 1'b0; cw_a = 0; cw_d = '0;
      for (int b = 0; b < NB; b++)
        if (pa_en[b]) exp_pa[b] = mdl[b][pa_addr[b*AW +: AW]];
      h_take = host_req && !m_busy;
      exp_hrv = h_take && !host_we;
      if (exp_hrv) exp_hrd = mdl[host_bank][host_addr];
      if (m_busy) begin
        if (m_same) begin
          if (m_k % 2 == 0) m_q.push_back(mdl[m_src][(m_sa + m_k/2) % DEPTH]);
          else begin cw = 1'b1; cw_a = (m_da + m_k/2) % DEPTH; cw_d = m_q.pop_front(); end
        end else begin
          if (m_k >= 1) begin cw = 1'b1; cw_a = (m_da + m_k - 1) % DEPTH; cw_d = m_q.pop_front(); end
          if (m_k < m_len) m_q.push_back(mdl[m_src][(m_sa + m_k) % DEPTH]);
        end
      end
      if (cw) mdl[m_dst][cw_a] = cw_d;
      if (h_take && host_we) mdl[host_bank][host_addr] = host_wdata;
      for (int b = 0; b < NB; b++)
        if (pa_en[b] && pa_we[b]) mdl[b][pa_addr[b*AW +: AW]] = pa_wdata[b*DW +: DW];
      if (m_busy) begin
        m_k++;
        if (m_k == m_t) m_busy = 1'b0;
      end else if (cp_valid && cp_len != 0) begin
        m_busy = 1'b1; m_k = 0; m_len = int'(cp_len);
        m_src = int'(cp_src_bank); m_dst = int'(cp_dst_bank);
        m_sa = int'(cp_src_addr); m_da = int'(cp_dst_addr);
        m_same = (cp_src_bank == cp_dst_bank);
        m_t = m_same ? 2*m_len : m_len + 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  bit model_on = 1'b0;
  always @(negedge clk) begin
    if (rst_n && model_on && !finished) begin
      chk(busy == m_busy, "R7 busy vs model", {31'b0, busy}, {31'b0, m_busy});
      chk(host_ready == !m_busy, "R6 ready vs model", {31'b0, host_ready}, {31'b0, !m_busy});
      chk(host_rvalid == exp_hrv, "R5 rvalid vs model", {31'b0, host_rvalid}, {31'b0, exp_hrv});
      if (exp_hrv) chk(host_rdata == exp_hrd, "R5 host rdata vs model", host_rdata, exp_hrd);
      for (int b = 0; b < NB; b++)
        chk(pa_rdata[b*DW +: DW] === exp_pa[b], "R2 port A rdata vs model",
            pa_rdata[b*DW +: DW], exp_pa[b]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic host_op(input bit we, input int bank, input int addr, input logic [DW-1:0] d);
    bit was;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_bank = bank[0]; host_addr = addr[AW-1:0]; host_wdata = d;
    forever begin
      was = host_ready;
      @(posedge clk);
      if (was) break;
      @(negedge clk);
    end
    #1 host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read_chk(input int bank, input int addr, input logic [DW-1:0] exp, input string tag);
    host_op(1'b0, bank, addr, '0);
    @(negedge clk);
    chk(host_rvalid && host_rdata == exp, tag, host_rdata, exp);
  endtask

  task automatic issue_copy(input int sb, input int db, input int sa, input int da, input int len);
    cp_valid = 1'b1; cp_src_bank = sb[0]; cp_dst_bank = db[0];
    cp_src_addr = sa[AW-1:0]; cp_dst_addr = da[AW-1:0]; cp_len = len[AW:0];
  endtask

  task automatic count_busy(output int cnt);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy after reset", {31'b0, busy}, 32'd0);
    chk(host_ready == 1'b1, "R1 ready after reset", {31'b0, host_ready}, 32'd1);
    chk(host_rvalid == 1'b0, "R1 rvalid after reset", {31'b0, host_rvalid}, 32'd0);
    chk(pa_rdata == '0, "R1 port A rdata after reset", pa_rdata[DW-1:0], '0);
    model_on = 1'b1;

    // fill both banks through port A
    for (int a = 0; a < DEPTH; a++) begin
      pa_en = '1; pa_we = '1;
      for (int b = 0; b < NB; b++) begin
        pa_addr[b*AW +: AW] = AW'(a);
        pa_wdata[b*DW +: DW] = pat(b, a);
      end
      @(negedge clk);
    end
    pa_en = '0; pa_we = '0;

    // R2 independent port A reads
    pa_en = '1; pa_addr = {8'd99, 8'd77};
    @(negedge clk);
    pa_en = '0;
    chk(pa_rdata[DW-1:0] == pat(0, 77), "R2 bank0 port A read", pa_rdata[DW-1:0], pat(0, 77));
    chk(pa_rdata[2*DW-1:DW] == pat(1, 99), "R2 bank1 port A read", pa_rdata[2*DW-1:DW], pat(1, 99));

    // R5 host write then read
    host_op(1'b1, 1, 5, 32'hDEAD_0005);
    host_read_chk(1, 5, 32'hDEAD_0005, "R5 host write/read");

    // R3 same-address collision, port A vs host
    @(negedge clk);
    pa_en = 2'b01; pa_we = 2'b01; pa_addr[AW-1:0] = 8'd7; pa_wdata[DW-1:0] = 32'h1111_1111;
    host_req = 1'b1; host_we = 1'b1; host_bank = 1'b0; host_addr = 8'd7; host_wdata = 32'h2222_2222;
    @(negedge clk);
    pa_en = '0; pa_we = '0; host_req = 1'b0; host_we = 1'b0;
    host_read_chk(0, 7, 32'h1111_1111, "R3 port A wins collision");

    // R4 read-first: port A read while host writes same address
    @(negedge clk);
    pa_en = 2'b10; pa_we = 2'b00; pa_addr[2*AW-1:AW] = 8'd20;
    host_req = 1'b1; host_we = 1'b1; host_bank = 1'b1; host_addr = 8'd20; host_wdata = 32'h3333_3333;
    @(negedge clk);
    pa_en = '0; host_req = 1'b0; host_we = 1'b0;
    chk(pa_rdata[2*DW-1:DW] == pat(1, 20), "R4 read returns old word", pa_rdata[2*DW-1:DW], pat(1, 20));
    host_read_chk(1, 20, 32'h3333_3333, "R4 write landed");

    // R7 cross-bank copy with a held host write (R6)
    @(negedge clk);
    issue_copy(0, 1, 10, 40, 8);
    @(negedge clk);
    cp_valid = 1'b0;
    fork
      begin
        count_busy(cnt);
        chk(cnt == 9, "R7 cross copy busy cycles", cnt, 32'd9);
      end
      begin
        host_op(1'b1, 1, 200, 32'h4444_4444);
      end
      begin
        @(negedge clk);
        chk(host_ready == 1'b0, "R6 ready low while busy", {31'b0, host_ready}, 32'd0);
        pa_en = 2'b10; pa_we = 2'b00; pa_addr[2*AW-1:AW] = 8'd200;
        @(negedge clk);
        pa_en = '0;
        chk(pa_rdata[2*DW-1:DW] == pat(1, 200), "R6 held write not early",
            pa_rdata[2*DW-1:DW], pat(1, 200));
      end
    join
    for (int i = 0; i < 8; i++)
      host_read_chk(1, 40 + i, pat(0, 10 + i), "R7 cross copy data");
    host_read_chk(1, 200, 32'h4444_4444, "R6 held write serviced");

    // R8 same-bank copy, plus R9 command while busy
    @(negedge clk);
    issue_copy(1, 1, 40, 100, 5);
    @(negedge clk);
    issue_copy(0, 0, 0, 150, 4);
    @(negedge clk);
    cp_valid = 1'b0;
    count_busy(cnt);
    chk(cnt == 9, "R8 same-bank copy busy cycles (after 1 already seen)", cnt, 32'd9);
    for (int i = 0; i < 5; i++)
      host_read_chk(1, 100 + i, pat(0, 10 + i), "R8 same-bank copy data");
    host_read_chk(0, 150, pat(0, 150), "R9 busy command ignored");

    // R9 zero-length command
    @(negedge clk);
    issue_copy(0, 1, 0, 0, 0);
    @(negedge clk);
    cp_valid = 1'b0;
    chk(busy == 1'b0, "R9 zero length ignored", {31'b0, busy}, 32'd0);
    host_read_chk(1, 0, pat(1, 0), "R9 zero length no write");

    // R10 wrapping copy, with port A write racing the first copy write (R3)
    @(negedge clk);
    issue_copy(1, 0, 250, 252, 8);
    @(negedge clk);
    cp_valid = 1'b0;
    @(negedge clk);
    pa_en = 2'b01; pa_we = 2'b01; pa_addr[AW-1:0] = 8'd252; pa_wdata[DW-1:0] = 32'h5555_5555;
    @(negedge clk);
    pa_en = '0; pa_we = '0;
    count_busy(cnt);
    host_read_chk(0, 252, 32'h5555_5555, "R3 port A beats copy write");
    host_read_chk(0, 253, pat(1, 251), "R10 copy before wrap");
    host_read_chk(0, 1, pat(1, 255), "R10 destination wrapped");
    host_read_chk(0, 2, pat(1, 0), "R10 source wrapped");
    host_read_chk(0, 3, pat(1, 1), "R10 last word");
    host_read_chk(0, 4, pat(0, 4), "R10 copy stops at length");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule